// File: doc/BRIEF.md
# Six-Region Banked Memory Mapper with Register Readback

This block sits between an 8-bit CPU bus and two memories: a large ROM and a single 8 kB RAM. It splits the lower 48 kB of the 64 kB CPU address space into six windows of 8 kB. Each window has its own 8-bit bank code. A bank code picks one of three things: a 7-bit ROM page, the shared RAM, or an empty hole that reads as all ones. Every window that selects RAM sees the same RAM bytes. The top 16 kB of the address space is never mapped.

Software loads the bank codes by writing to switch addresses in the upper part of window 3. The order of the switch addresses does not follow the window numbers. A control byte at a fixed address holds an enable bit. While that bit is set, an 8-byte readback area exposes the bank codes. The read path is purely combinational from the address and the memory data inputs. Register updates take effect at the clock edge that samples a write strobe.

Top module: `bank_mapper`

## Requirements
- R1: After reset, all six bank codes hold 0xA8 and the control byte holds 0, so the readback area is hidden and every window maps ROM page 0x28.
- R2: A write to an address in 0x6000–0x7FEF loads one bank code, selected by address bits 12:10: code 0 loads window 2, 1 loads window 0, 2 loads window 3, 3 loads window 1, 4 loads window 4 and 6 loads window 5.
- R3: In that range, address bits 12:10 equal to 5 or 7 change no bank code.
- R4: A write to 0x7FF9 loads the control byte. While control bit 2 is 1, a read of 0x7FF0+k returns bank code k for k in 0..5, and returns 0 for k = 6 or 7.
- R5: A bank code from 0x80 to 0x8F with bit 2 set maps the shared RAM. The window then reads RAM byte (address & 0x1FFF), and every RAM-mapped window sees the same bytes.
- R6: A bank code from 0x80 to 0x8F with bit 2 clear makes the window read 0xFF.
- R7: Any other bank code maps ROM page (code & 0x7F), so codes 0x90–0xFF alias 0x10–0x7F. The 20-bit ROM address is {page, address[12:0]}.
- R8: Reads at 0xC000–0xFFFF return 0xFF.
- R9: A write outside the switch range and the control address reaches the RAM at index (address & 0x1FFF) only if the addressed window maps RAM. Switch and control writes never reach the RAM.
- R10: When readback is enabled, the readback area takes priority over the RAM or ROM mapping of window 3.
- R11: While the read strobe is low, the read data output is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| cpu_rdata | output | 8 | Read data, combinational |
| rom_addr | output | 20 | ROM byte address {page, offset} |
| rom_data | input | 8 | ROM byte at rom_addr |
| ram_addr | output | 13 | RAM byte index |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable for the current edge |
| ram_rdata | input | 8 | RAM byte at ram_addr |

## Verification
Two functions can overlap on the same address. The switch range and the readback area both lie inside window 3, and window 3 may itself map RAM. A single write can therefore hit both a bank code and a live RAM byte, and a single read can hit both the readback area and a RAM byte. The bench maps RAM into window 3 and then does three things: it writes switch and control addresses, it reads the readback area with the enable bit set and then cleared, and it mixes such accesses into random traffic. Each result is checked against a reference model that keeps the RAM image separately. A stray RAM write is caught when the affected byte is later read through another RAM-mapped window.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    localparam int BM_ADDR_W  = 16;
    localparam int BM_DATA_W  = 8;
    localparam int BM_PAGE_W  = 7;
    localparam int BM_OFFS_W  = 13;

    // switch range and special addresses
    localparam logic [BM_ADDR_W-1:0] SW_LO     = 16'h6000;
    localparam logic [BM_ADDR_W-1:0] RB_BASE   = 16'h7FF0;
    localparam logic [BM_ADDR_W-1:0] CTRL_ADDR = 16'h7FF9;
    localparam int                   SW_SEL_LSB = 10;
    localparam int                   RB_EN_BIT  = 2;

    typedef enum logic [1:0] {
        MAP_ROM  = 2'd0,
        MAP_RAM  = 2'd1,
        MAP_HOLE = 2'd2
    } map_kind_e;

endpackage

// File: rtl/bm_code_decode.sv
module bm_code_decode
    import bank_mapper_pkg::*;
#(
    parameter int DATA_W = BM_DATA_W,
    parameter int PAGE_W = BM_PAGE_W
) (
    input  logic [DATA_W-1:0] code,
    output map_kind_e         kind,
    output logic [PAGE_W-1:0] page
);

    localparam int HI_W = DATA_W - 4;
    localparam logic [HI_W-1:0] SPECIAL_HI = HI_W'(1) << (HI_W - 1);

    logic special;

    always_comb begin
        special = (code[DATA_W-1:4] == SPECIAL_HI);
        page    = code[PAGE_W-1:0];
        if (special) begin
            kind = code[2] ? MAP_RAM : MAP_HOLE;
        end else begin
            kind = MAP_ROM;
        end
    end

endmodule

// File: rtl/bm_switch_decode.sv
module bm_switch_decode
    import bank_mapper_pkg::*;
#(
    parameter int ADDR_W      = BM_ADDR_W,
    parameter int NUM_REGIONS = 6
) (
    input  logic [ADDR_W-1:0]      addr,
    output logic                   in_switch,
    output logic                   in_ctrl,
    output logic [NUM_REGIONS-1:0] sel_oh
);

    localparam int SEL_W = 3;
    localparam int NONE  = 15;
    // scrambled slot code -> window index (NONE = ignored)
    localparam logic [3:0] SLOT_MAP [1 << SEL_W] =
        '{4'd2, 4'd0, 4'd3, 4'd1, 4'd4, 4'(NONE), 4'd5, 4'(NONE)};

    logic [SEL_W-1:0] slot_code;
    logic [3:0]       target;

    always_comb begin
        in_switch = (addr >= SW_LO) && (addr < RB_BASE);
        in_ctrl   = (addr == CTRL_ADDR);
        slot_code = addr[SW_SEL_LSB +: SEL_W];
        target    = SLOT_MAP[slot_code];
        sel_oh    = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (in_switch && (int'(target) == r)) begin
                sel_oh[r] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int                 NUM_REGIONS = 6,
    parameter int                 ADDR_W      = BM_ADDR_W,
    parameter int                 DATA_W      = BM_DATA_W,
    parameter int                 PAGE_W      = BM_PAGE_W,
    parameter int                 OFFS_W      = BM_OFFS_W,
    parameter logic [DATA_W-1:0]  RESET_BANK  = 8'hA8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    output logic [DATA_W-1:0]         cpu_rdata,
    output logic [PAGE_W+OFFS_W-1:0]  rom_addr,
    input  logic [DATA_W-1:0]         rom_data,
    output logic [OFFS_W-1:0]         ram_addr,
    output logic [DATA_W-1:0]         ram_wdata,
    output logic                      ram_we,
    input  logic [DATA_W-1:0]         ram_rdata
);

    localparam int RGN_W     = ADDR_W - OFFS_W;
    localparam int NUM_SLOTS = 1 << RGN_W;
    localparam int RB_IDX_W  = 3;
    localparam int RB_SLOTS  = 1 << RB_IDX_W;

    typedef struct packed {
        logic [NUM_REGIONS-1:0][DATA_W-1:0] bank;
        logic [DATA_W-1:0]                  ctrl;
    } state_t;

    state_t st_d, st_q;

    // ---------------- write-side decode ----------------
    logic                   sw_win;
    logic                   ctrl_hit;
    logic [NUM_REGIONS-1:0] sw_sel;

    bm_switch_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_REGIONS (NUM_REGIONS)
    ) u_sw (
        .addr      (cpu_addr),
        .in_switch (sw_win),
        .in_ctrl   (ctrl_hit),
        .sel_oh    (sw_sel)
    );

    // ---------------- per-window bank decode ----------------
    map_kind_e         kind_all [NUM_SLOTS];
    logic [PAGE_W-1:0] page_all [NUM_SLOTS];

    for (genvar r = 0; r < NUM_SLOTS; r++) begin : g_win
        if (r < NUM_REGIONS) begin : g_mapped
            bm_code_decode #(
                .DATA_W (DATA_W),
                .PAGE_W (PAGE_W)
            ) u_dec (
                .code (st_q.bank[r]),
                .kind (kind_all[r]),
                .page (page_all[r])
            );
        end else begin : g_unmapped
            assign kind_all[r] = MAP_HOLE;
            assign page_all[r] = '0;
        end
    end

    // ---------------- readback slots ----------------
    logic [DATA_W-1:0] rb_regs [RB_SLOTS];

    for (genvar k = 0; k < RB_SLOTS; k++) begin : g_rb
        if (k < NUM_REGIONS) begin : g_live
            assign rb_regs[k] = st_q.bank[k];
        end else begin : g_zero
            assign rb_regs[k] = '0;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (cpu_wr) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (sw_sel[r]) begin
                    st_d.bank[r] = cpu_wdata;
                end
            end
            if (ctrl_hit) begin
                st_d.ctrl = cpu_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.bank <= {NUM_REGIONS{RESET_BANK}};
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read path ----------------
    logic [RGN_W-1:0]    rgn;
    logic                rgn_valid;
    map_kind_e           cur_kind;
    logic [PAGE_W-1:0]   cur_page;
    logic                rb_hit;
    logic [RB_IDX_W-1:0] rb_idx;

    always_comb begin
        rgn       = cpu_addr[ADDR_W-1:OFFS_W];
        rgn_valid = (int'(rgn) < NUM_REGIONS);
        cur_kind  = kind_all[rgn];
        cur_page  = page_all[rgn];
        rb_idx    = cpu_addr[RB_IDX_W-1:0];
        rb_hit    = st_q.ctrl[RB_EN_BIT] &&
                    (cpu_addr[ADDR_W-1:RB_IDX_W] == RB_BASE[ADDR_W-1:RB_IDX_W]);

        rom_addr  = {cur_page, cpu_addr[OFFS_W-1:0]};
        ram_addr  = cpu_addr[OFFS_W-1:0];
        ram_wdata = cpu_wdata;
        ram_we    = cpu_wr && !sw_win && !ctrl_hit && rgn_valid &&
                    (cur_kind == MAP_RAM);

        if (!cpu_rd || !rgn_valid) begin
            cpu_rdata = '1;
        end else if (rb_hit) begin
            cpu_rdata = rb_regs[rb_idx];
        end else begin
            unique case (cur_kind)
                MAP_RAM:  cpu_rdata = ram_rdata;
                MAP_ROM:  cpu_rdata = rom_data;
                default:  cpu_rdata = '1;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_SLOT_ONE_LOADS_WIN0: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && sw_win && cpu_addr[SW_SEL_LSB +: 3] == 3'd1)
        |=> (st_q.bank[0] == $past(cpu_wdata))); // R2

    AST_IGNORED_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && sw_win && cpu_addr[SW_SEL_LSB] && cpu_addr[SW_SEL_LSB+2])
        |=> $stable(st_q.bank)); // R3

    AST_CTRL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == CTRL_ADDR)
        |=> (st_q.ctrl == $past(cpu_wdata))); // R4

    AST_RAM_WE_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (cpu_wr && !sw_win && !ctrl_hit)); // R9

    AST_TOP_RANGE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b11)
        |-> (cpu_rdata == '1)); // R8

    AST_IDLE_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> (cpu_rdata == '1)); // R11

endmodule

// File: tb/sim_bank_mapper.sv
`timescale 1ns/1ps
module sim_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [19:0] rom_addr;
    logic [7:0]  rom_data;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        ram_we;
    logic [7:0]  ram_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bank_mapper u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .rom_addr(rom_addr), .rom_data(rom_data), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_we(ram_we), .ram_rdata(ram_rdata)
    );

    // memories seen by the design
    logic [7:0] dev_ram [8192];
    function automatic logic [7:0] rom_f(logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
    endfunction
    assign rom_data  = rom_f(rom_addr);
    assign ram_rdata = dev_ram[ram_addr];
    always @(posedge clk) if (ram_we) dev_ram[ram_addr] <= ram_wdata;

    // reference model
    logic [7:0] m_bank [6];
    logic [7:0] m_ctrl;
    logic [7:0] ref_ram [8192];

    function automatic bit is_ram(logic [7:0] c);
        return (c[7:4] == 4'h8) && c[2];
    endfunction

    function automatic logic [7:0] exp_read(logic [15:0] a);
        int rg = int'(a[15:13]);
        logic [7:0] c;
        if (rg >= 6) return 8'hFF;
        if (m_ctrl[2] && a[15:3] == 13'h0FFE)
            return (int'(a[2:0]) < 6) ? m_bank[a[2:0]] : 8'h00;
        c = m_bank[rg];
        if (c[7:4] == 4'h8) return c[2] ? ref_ram[a[12:0]] : 8'hFF;
        return rom_f({c[6:0], a[12:0]});
    endfunction

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        int rg = int'(a[15:13]);
        if (a >= 16'h6000 && a < 16'h7FF0) begin
            case (a[12:10])
                3'd0: m_bank[2] = d;
                3'd1: m_bank[0] = d;
                3'd2: m_bank[3] = d;
                3'd3: m_bank[1] = d;
                3'd4: m_bank[4] = d;
                3'd6: m_bank[5] = d;
                default: ;
            endcase
        end else if (a == 16'h7FF9) begin
            m_ctrl = d;
        end else if (rg < 6 && is_ram(m_bank[rg])) begin
            ref_ram[a[12:0]] = d;
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp, logic [15:0] a);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, a, act, exp);
        end
    endtask

    task automatic rd(string req, logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1;
        check(req, cpu_rdata, exp_read(a), a);
        cpu_rd = 1'b0;
    endtask

    task automatic dump_rb(string req);
        for (int k = 0; k < 8; k++) rd(req, 16'h7FF0 + 16'(k));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8192; i++) begin
            dev_ram[i] = 8'(i * 7 + 3);
            ref_ram[i] = 8'(i * 7 + 3);
        end
        for (int r = 0; r < 6; r++) m_bank[r] = 8'hA8;
        m_ctrl = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, readback hidden, ROM page 0x28
        rd("R1", 16'h7FF0);
        rd("R1", 16'h0123);
        @(negedge clk); cpu_addr = 16'h2456; #1;
        n_checks++;
        if (rom_addr !== {7'h28, 13'h0456}) begin
            n_fail++;
            $display("FAIL R7 rom_addr actual=%h expected=%h", rom_addr, {7'h28, 13'h0456});
        end
        wr(16'h7FF9, 8'h04);
        dump_rb("R1");                       // also R4: slots 6,7 read 0

        // R2: scrambled switch addresses
        wr(16'h6000, 8'h12); wr(16'h6400, 8'h20); wr(16'h6800, 8'h33);
        wr(16'h6C00, 8'h41); wr(16'h7000, 8'h55); wr(16'h7800, 8'h66);
        dump_rb("R2");
        // R3: ignored slot codes
        wr(16'h7400, 8'hEE); wr(16'h7C00, 8'hDD); wr(16'h77FF, 8'hCC);
        dump_rb("R3");
        // R4: readback off again
        wr(16'h7FF9, 8'hFB);
        rd("R4", 16'h7FF2);

        // R5: shared RAM across windows
        wr(16'h6000, 8'h84);                 // window 2 -> RAM
        wr(16'h6400, 8'h8C);                 // window 0 -> RAM
        wr(16'h4010, 8'hA5);
        rd("R5", 16'h0010);
        rd("R5", 16'h4010);
        // R6: hole
        wr(16'h6C00, 8'h83);
        rd("R6", 16'h2010);
        wr(16'h2010, 8'h11);                 // must not touch RAM
        rd("R6", 16'h0010);
        rd("R9", 16'h0010);
        // R7: ROM aliasing
        wr(16'h7000, 8'h95); rd("R7", 16'h8ABC);
        wr(16'h7000, 8'h15); rd("R7", 16'h8ABC);
        // R8
        rd("R8", 16'hC000); rd("R8", 16'hFFFF);
        // R10/R9: window 3 RAM with readback and switch overlap
        wr(16'h6800, 8'h87);
        wr(16'h7FF9, 8'h04);
        rd("R10", 16'h7FF0); rd("R10", 16'h7FF3);
        wr(16'h7FF9, 8'h00);
        rd("R10", 16'h7FF0);
        wr(16'h7000, 8'h86);                 // switch write, window 3 RAM
        rd("R9", 16'h1000);                  // RAM[0x1000] untouched
        rd("R9", 16'h1FF9);                  // control write didn't land
        wr(16'h7FFC, 8'h3C);
        rd("R9", 16'h1FFC);
        // R11
        @(negedge clk); cpu_addr = 16'h0010; cpu_rd = 1'b0; #1;
        check("R11", cpu_rdata, 8'hFF, cpu_addr);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel = int'($urandom_range(0, 99));
            logic [15:0] a = 16'($urandom);
            logic [7:0]  d = 8'($urandom);
            if (sel < 25) begin
                a = 16'h6000 + 16'($urandom_range(0, 16'h1FEF));
                if ($urandom_range(0, 1) == 1) d = 8'h80 | 8'($urandom_range(0, 15));
                wr(a, d);
            end else if (sel < 30) begin
                wr(16'h7FF9, d);
            end else if (sel < 45) begin
                rd("R4", 16'h7FF0 + 16'($urandom_range(0, 15)));
            end else if (sel < 65) begin
                wr(a, d);
            end else begin
                rd("R7", a);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule